// File: doc/BRIEF.md
# Single-Pin GPIO Controller with Interrupt Detection

This block controls one general-purpose pin. Software reaches it through a small word-addressed register window on a synchronous read/write bus. Through that window it chooses the pin direction and the level it drives, and it can float the driver. It reads back the pin level after that level has passed a two-flop synchronizer and an optional debounce filter. The debounce filter counts an external one-cycle millisecond tick.

A detector watches the filtered level and sets a sticky interrupt status bit. It can be set to no detection, level detection, single-edge detection or detection on both edges, and one polarity bit chooses high/rising or low/falling. Software clears the status by writing the clear register. The status leaves the block unmasked on `irq_raw`, for a bank-level aggregator, and masked by the interrupt enable on `irq`.

Top module: `pin_io_unit`

## Requirements
- R1: After reset the configuration word and the debounce threshold read 0, and the float bit at word 0x0C reads 1. `pad_oe`, `irq` and `irq_raw` are all 0.
- R2: Word 0x00 stores config bits 7:0 and word 0x04 stores a threshold in bits 7:0. Both read back what was written, with upper bits reading 0. Config bit 7 is a timestamp flag that is only stored.
- R3: `pad_oe` is 1 only when config bit 0 (pin enable) is 1, config bit 1 (output direction) is 1 and bit 0 of word 0x0C (float) is 0. `pad_out` follows bit 0 of word 0x10.
- R4: Bit 0 of word 0x08 returns the pin level after a two-flop synchronizer, when the filter is bypassed.
- R5: When config bit 5 (debounce) is 1 and the threshold N is nonzero, the filtered level takes a new pin value only on the N-th tick of `ms_tick` that arrives while the synchronized input stays different from it. Any return to the old level restarts the count.
- R6: A threshold of 0 bypasses the filter even when config bit 5 is 1.
- R7: Config bits 3:2 select the trigger as 0 none, 1 level, 2 single edge, 3 both edges. In single-edge mode, config bit 4 = 1 fires on a rising edge and 0 fires on a falling edge.
- R8: In both-edge mode every rising and every falling edge sets the status.
- R9: In level mode, with bit 4 = 1 meaning high, the status sets again on the cycle after a clear while the level persists. Trigger type 0, or pin enable 0, never sets the status.
- R10: Writing word 0x14 with bit 0 = 1 clears the status. Writing it with bit 0 = 0 has no effect. A qualifying edge in the same cycle as a clear leaves the status set.
- R11: `irq` equals the status gated by config bit 6. The status, seen on `irq_raw`, latches even while bit 6 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle, 0 when not selected |
| pad_in | input | 1 | Asynchronous pin level |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pad_out | output | 1 | Level to drive |
| pad_oe | output | 1 | Driver enable |
| irq | output | 1 | Masked interrupt request |
| irq_raw | output | 1 | Unmasked latched status |

## Verification
Two things can land on the same clock edge: a software clear and a freshly detected edge. To provoke this, the bench counts the synchronizer and filter registers so that the clear write is sampled on exactly the edge where the filtered level has just changed. It then expects `irq_raw` to stay 1. The contrasting case is level mode. There the clear wins for one cycle, and the bench samples the gap right after the clear and then the re-set on the following cycle.

// File: rtl/pin_io_pkg.sv
package pin_io_pkg;

    // Word indices inside the per-pin window (byte offset / 4)
    localparam int unsigned WORD_CFG   = 0;
    localparam int unsigned WORD_THR   = 1;
    localparam int unsigned WORD_LEVEL = 2;
    localparam int unsigned WORD_FLOAT = 3;
    localparam int unsigned WORD_DRIVE = 4;
    localparam int unsigned WORD_CLEAR = 5;

    typedef enum logic [1:0] {
        TRIG_OFF      = 2'd0,
        TRIG_LEVEL    = 2'd1,
        TRIG_ONE_EDGE = 2'd2,
        TRIG_TWO_EDGE = 2'd3
    } trig_t;

    // Bit 7 down to bit 0 of the configuration word
    typedef struct packed {
        logic  stamp;
        logic  irq_en;
        logic  deb_en;
        logic  pol;
        trig_t trig;
        logic  out_dir;
        logic  pin_en;
    } pin_cfg_t;

    localparam int unsigned CFG_W = $bits(pin_cfg_t);

    function automatic logic word_hit(input logic [7:0] widx, input int unsigned which);
        return widx == 8'(which);
    endfunction

endpackage

// File: rtl/pin_io_regs.sv
module pin_io_regs
    import pin_io_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              level_in,
    output logic [DATA_W-1:0] rdata,
    output pin_cfg_t          cfg_q,
    output logic [THR_W-1:0]  thr_q,
    output logic              float_q,
    output logic              drive_q,
    output logic              clr_pulse
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [7:0] widx;
    logic       we;
    logic       hit_cfg, hit_thr, hit_lvl, hit_flt, hit_drv, hit_clr;
    logic       wr_unused;

    assign widx    = 8'(addr[ADDR_W-1:2]);
    assign we      = sel & wr;
    assign hit_cfg = word_hit(widx, WORD_CFG);
    assign hit_thr = word_hit(widx, WORD_THR);
    assign hit_lvl = word_hit(widx, WORD_LEVEL);
    assign hit_flt = word_hit(widx, WORD_FLOAT);
    assign hit_drv = word_hit(widx, WORD_DRIVE);
    assign hit_clr = word_hit(widx, WORD_CLEAR);

    assign wr_unused = ^{wdata[DATA_W-1:CFG_W], addr[1:0], WORD_W[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            thr_q   <= '0;
            float_q <= 1'b1;
            drive_q <= 1'b0;
        end else if (we) begin
            if (hit_cfg) cfg_q   <= pin_cfg_t'(wdata[CFG_W-1:0]);
            if (hit_thr) thr_q   <= wdata[THR_W-1:0];
            if (hit_flt) float_q <= wdata[0];
            if (hit_drv) drive_q <= wdata[0];
        end
    end

    assign clr_pulse = we & hit_clr & wdata[0];

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (hit_cfg) rdata[CFG_W-1:0] = cfg_q;
            if (hit_thr) rdata[THR_W-1:0] = thr_q;
            if (hit_lvl) rdata[0]         = level_in;
            if (hit_flt) rdata[0]         = float_q;
            if (hit_drv) rdata[0]         = drive_q;
        end
    end

endmodule

// File: rtl/pin_io_filter.sv
module pin_io_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned THR_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pad_in,
    input  logic             tick,
    input  logic             filt_on,
    input  logic [THR_W-1:0] thr,
    output logic             level
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   synced;
    logic [THR_W-1:0]       cnt;
    logic [THR_W:0]         cnt_next;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pad_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_STAGES-2:0], pad_in};
            end
        end
    endgenerate

    assign synced   = chain[SYNC_STAGES-1];
    assign cnt_next = {1'b0, cnt} + (THR_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
        end else if (!filt_on) begin
            level <= synced;
            cnt   <= '0;
        end else if (synced == level) begin
            cnt   <= '0;
        end else if (tick) begin
            if (cnt_next >= {1'b0, thr}) begin
                level <= synced;
                cnt   <= '0;
            end else begin
                cnt   <= cnt_next[THR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/pin_io_trigger.sv
module pin_io_trigger
    import pin_io_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  level,
    input  logic  pin_en,
    input  trig_t trig,
    input  logic  pol,
    input  logic  clr,
    output logic  edge_hit,
    output logic  lvl_hit,
    output logic  status
);
    logic prev;
    logic rise, fall;

    assign rise = level & ~prev;
    assign fall = ~level & prev;

    always_comb begin
        edge_hit = 1'b0;
        lvl_hit  = 1'b0;
        if (pin_en) begin
            unique case (trig)
                TRIG_LEVEL:    lvl_hit  = (level == pol);
                TRIG_ONE_EDGE: edge_hit = pol ? rise : fall;
                TRIG_TWO_EDGE: edge_hit = rise | fall;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            status <= 1'b0;
        end else begin
            prev   <= level;
            // a fresh edge outranks a clear; a clear outranks a held level
            status <= edge_hit | ((lvl_hit | status) & ~clr);
        end
    end

endmodule

// File: rtl/pin_io_unit.sv
module pin_io_unit
    import pin_io_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned THR_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pad_in,
    input  logic              ms_tick,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              irq,
    output logic              irq_raw
);
    pin_cfg_t         cfg_q;
    logic [THR_W-1:0] thr_q;
    logic             float_q;
    logic             drive_q;
    logic             clr_pulse;
    logic             flt_level;
    logic             deb_act;
    logic             edge_hit;
    logic             lvl_hit;
    logic             status_q;
    logic             cfg_unused;

    pin_io_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .THR_W(THR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .sel       (bus_sel),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .level_in  (flt_level),
        .rdata     (bus_rdata),
        .cfg_q     (cfg_q),
        .thr_q     (thr_q),
        .float_q   (float_q),
        .drive_q   (drive_q),
        .clr_pulse (clr_pulse)
    );

    assign deb_act = cfg_q.deb_en & (thr_q != '0);

    pin_io_filter #(.SYNC_STAGES(SYNC_STAGES), .THR_W(THR_W)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .tick    (ms_tick),
        .filt_on (deb_act),
        .thr     (thr_q),
        .level   (flt_level)
    );

    pin_io_trigger u_trig (
        .clk      (clk),
        .rst      (rst),
        .level    (flt_level),
        .pin_en   (cfg_q.pin_en),
        .trig     (cfg_q.trig),
        .pol      (cfg_q.pol),
        .clr      (clr_pulse),
        .edge_hit (edge_hit),
        .lvl_hit  (lvl_hit),
        .status   (status_q)
    );

    assign cfg_unused = cfg_q.stamp;

    assign pad_out = drive_q;
    assign pad_oe  = cfg_q.pin_en & cfg_q.out_dir & ~float_q;
    assign irq_raw = status_q;
    assign irq     = status_q & cfg_q.irq_en;

endmodule

// File: rtl/pin_io_unit_chk.sv
module pin_io_unit_chk (
    input logic clk,
    input logic rst,
    input logic irq,
    input logic irq_raw,
    input logic pad_oe,
    input logic float_q,
    input logic clr_pulse,
    input logic edge_hit,
    input logic lvl_hit,
    input logic flt_level,
    input logic deb_act,
    input logic ms_tick
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_raw && !pad_oe));

    // R3
    oe_float_chk: assert property (@(posedge clk) disable iff (rst) pad_oe |-> !float_q);

    // R5
    filter_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(deb_act) && !$stable(flt_level)) |-> $past(ms_tick));

    // R9
    level_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_raw && lvl_hit && !clr_pulse) |=> irq_raw);

    // R10
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !edge_hit) |=> !irq_raw);

    // R10
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> irq_raw);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst) irq |-> irq_raw);

endmodule

bind pin_io_unit pin_io_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .irq_raw   (irq_raw),
    .pad_oe    (pad_oe),
    .float_q   (float_q),
    .clr_pulse (clr_pulse),
    .edge_hit  (edge_hit),
    .lvl_hit   (lvl_hit),
    .flt_level (flt_level),
    .deb_act   (deb_act),
    .ms_tick   (ms_tick)
);

// File: tb/test_pin_io_unit.sv
module test_pin_io_unit;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              pad_in = 1'b0;
    logic              ms_tick = 1'b0;
    logic              pad_out, pad_oe, irq, irq_raw;

    always #2 clk = ~clk;

    pin_io_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_pin_io_unit (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .ms_tick(ms_tick), .pad_out(pad_out),
        .pad_oe(pad_oe), .irq(irq), .irq_raw(irq_raw)
    );

    // observable selectors
    localparam int SRC_RDATA = 0;
    localparam int SRC_IRQ   = 1;
    localparam int SRC_RAW   = 2;
    localparam int SRC_OE    = 3;
    localparam int SRC_OUT   = 4;

    typedef struct {
        string       tag;
        int          src;
        logic [31:0] exp;
    } item_t;

    item_t       sbq[$];
    item_t       cur;
    logic [31:0] act;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // monitor: pops expectations and compares against the live outputs
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            cur = sbq.pop_front();
            case (cur.src)
                SRC_RDATA: act = bus_rdata;
                SRC_IRQ:   act = {31'd0, irq};
                SRC_RAW:   act = {31'd0, irq_raw};
                SRC_OE:    act = {31'd0, pad_oe};
                default:   act = {31'd0, pad_out};
            endcase
            n_chk++;
            if (act !== cur.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0h expected %0h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic expect_obs(input string tag, input int src, input logic [31:0] exp);
        item_t it;
        it.tag = tag;
        it.src = src;
        it.exp = exp;
        sbq.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        expect_obs(tag, SRC_RDATA, exp);
        bus_sel = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_tick();
        @(posedge clk); #1 ms_tick = 1'b1;
        @(posedge clk); #1 ms_tick = 1'b0;
    endtask

    task automatic clear_status();
        bus_write(5'h14, 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_obs("R1 pad_oe", SRC_OE, 0);
        expect_obs("R1 irq", SRC_IRQ, 0);
        expect_obs("R1 irq_raw", SRC_RAW, 0);
        read_chk("R1 cfg", 5'h00, 32'h0);
        read_chk("R1 thr", 5'h04, 32'h0);
        read_chk("R1 float", 5'h0C, 32'h1);

        // R2 storage and width of config / threshold
        bus_write(5'h00, 32'hFFFF_FF80);
        read_chk("R2 cfg stamp stored", 5'h00, 32'h80);
        bus_write(5'h04, 32'h0000_01A5);
        read_chk("R2 thr", 5'h04, 32'hA5);
        bus_write(5'h04, 32'h0);

        // R3 output drive
        bus_write(5'h10, 32'h1);
        bus_write(5'h00, 32'h03);
        expect_obs("R3 floated", SRC_OE, 0);
        bus_write(5'h0C, 32'h0);
        expect_obs("R3 driving", SRC_OE, 1);
        expect_obs("R3 level", SRC_OUT, 1);
        bus_write(5'h00, 32'h02);
        expect_obs("R3 pin disabled", SRC_OE, 0);
        bus_write(5'h10, 32'h0);
        expect_obs("R3 level low", SRC_OUT, 0);

        // R4 synchronized input
        bus_write(5'h00, 32'h01);
        pad_in = 1'b1; settle(4);
        read_chk("R4 input high", 5'h08, 32'h1);
        pad_in = 1'b0; settle(4);
        read_chk("R4 input low", 5'h08, 32'h0);

        // R7 single edge, falling then rising
        bus_write(5'h00, 32'h49);
        pad_in = 1'b1; settle(6);
        expect_obs("R7 rise ignored in falling mode", SRC_RAW, 0);
        pad_in = 1'b0; settle(6);
        expect_obs("R7 falling fires", SRC_IRQ, 1);
        clear_status();
        expect_obs("R7 cleared", SRC_IRQ, 0);
        bus_write(5'h00, 32'h59);
        pad_in = 1'b1; settle(6);
        expect_obs("R7 rising fires", SRC_IRQ, 1);
        clear_status();

        // R8 both edges
        bus_write(5'h00, 32'h4D);
        pad_in = 1'b0; settle(6);
        expect_obs("R8 falling", SRC_IRQ, 1);
        clear_status();
        pad_in = 1'b1; settle(6);
        expect_obs("R8 rising", SRC_IRQ, 1);
        clear_status();

        // R11 masking
        bus_write(5'h00, 32'h0D);
        pad_in = 1'b0; settle(6);
        expect_obs("R11 masked irq", SRC_IRQ, 0);
        expect_obs("R11 raw latched", SRC_RAW, 1);
        bus_write(5'h00, 32'h4D);
        expect_obs("R11 unmasked", SRC_IRQ, 1);
        clear_status();

        // R9 level high
        bus_write(5'h00, 32'h55);
        settle(4);
        expect_obs("R9 low level quiet", SRC_RAW, 0);
        pad_in = 1'b1; settle(6);
        expect_obs("R9 level set", SRC_RAW, 1);
        clear_status();
        expect_obs("R9 gap after clear", SRC_RAW, 0);
        expect_obs("R9 re-set next cycle", SRC_RAW, 1);
        bus_write(5'h00, 32'h41);
        clear_status(); settle(4);
        expect_obs("R9 type none quiet", SRC_RAW, 0);
        bus_write(5'h00, 32'h54);
        clear_status(); settle(4);
        expect_obs("R9 pin disabled quiet", SRC_RAW, 0);

        // R10 clear register
        bus_write(5'h00, 32'h4D);
        pad_in = 1'b0; settle(6);
        expect_obs("R10 set", SRC_RAW, 1);
        bus_write(5'h14, 32'h0);
        expect_obs("R10 zero write ignored", SRC_RAW, 1);
        bus_write(5'h14, 32'h2);
        expect_obs("R10 bit1 write ignored", SRC_RAW, 1);
        clear_status();
        expect_obs("R10 cleared", SRC_RAW, 0);
        @(posedge clk); #1 pad_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h14; bus_wdata = 32'h1;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
        expect_obs("R10 edge beats clear", SRC_RAW, 1);
        clear_status();

        // R5 debounce, threshold 3
        bus_write(5'h00, 32'h21);
        bus_write(5'h04, 32'h3);
        pad_in = 1'b0; settle(5);
        read_chk("R5 held before ticks", 5'h08, 32'h1);
        pulse_tick(); pulse_tick();
        read_chk("R5 held after two ticks", 5'h08, 32'h1);
        pad_in = 1'b1; settle(4);
        pad_in = 1'b0; settle(4);
        pulse_tick(); pulse_tick();
        read_chk("R5 count restarted", 5'h08, 32'h1);
        pulse_tick();
        read_chk("R5 third tick switches", 5'h08, 32'h0);

        // R6 threshold zero bypasses
        bus_write(5'h04, 32'h0);
        pad_in = 1'b1; settle(4);
        read_chk("R6 bypass", 5'h08, 32'h1);

        settle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule